// File: doc/BRIEF.md
# Chip-Select Sequenced Converter Control

This block is the digital controller of a successive-approximation converter that has a parallel read-out port. One active-low chip-select line carries three successive falling edges, and each edge has its own meaning. The read/convert level is sampled at every falling edge, and together the two inputs pick acquisition, the power state after conversion, and when the result is driven out.

The first accepted edge, taken with read/convert low, powers the reference up and starts tracking the input. The second edge freezes the sample and starts a conversion. The read/convert level seen at this edge decides whether the reference stays on or is switched off once the conversion finishes. The conversion engine is abstract: a counter runs a set number of clocks, and when it ends the 14-bit result word is captured and end-of-conversion goes low. A third edge, taken with read/convert high, puts the result on an 8-bit port one byte at a time, chosen by a byte-select input. When chip-select rises again the port is released and end-of-conversion returns high.

Chip-select, read/convert and the block-reset request each pass through a two-flop synchronizer before use. Edges are found on the synchronized chip-select.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After system reset, eoc_n is 1, bus_oe is 0, ref_on is 0 and sampling is 0.
- R2: When the block is idle (reference off or on), a cs_n falling edge with rd_cnv low sets sampling to 1 and ref_on to 1.
- R3: When the block is idle, a cs_n falling edge with rd_cnv high is ignored: sampling stays 0 and ref_on keeps its value.
- R4: During acquisition, a cs_n falling edge clears sampling and starts a conversion. eoc_n stays 1 for CONV_CYCLES clocks after the conversion starts, then goes to 0.
- R5: The rd_cnv level at the conversion-start edge is latched. When it is 1, ref_on goes to 0 at the moment eoc_n falls. When it is 0, ref_on stays 1.
- R6: After a read, eoc_n returns to 1 once cs_n rises, and the block goes back to idle.
- R7: While eoc_n is 0, a cs_n falling edge with rd_cnv high sets bus_oe to 1. bus_oe goes back to 0 after cs_n rises.
- R8: bus_oe stays 0 throughout acquisition and conversion, and also while the result is waiting to be read.
- R9: With hi_byte_sel at 1, bus_dout is {2'b00, result[13:8]}. With hi_byte_sel at 0, bus_dout is result[7:0]. The result is straight binary, so full scale 16383 reads as 8'h3F and 8'hFF.
- R10: engine_result is captured in the clock in which the conversion ends. Later changes on engine_result do not alter the bytes that are read.
- R11: reset_req taken while cs_n is high puts the block into the reference-off idle state: eoc_n is 1, ref_on is 0, sampling is 0 and bus_oe is 0. The next cs_n falling edge with rd_cnv low starts acquisition. reset_req taken while cs_n is low is ignored.
- R12: While the result waits, a cs_n falling edge with rd_cnv low is ignored: bus_oe stays 0 and eoc_n stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| rd_cnv | input | 1 | Read/convert level, sampled at each cs_n falling edge |
| reset_req | input | 1 | Block reset request, active high, honoured only while cs_n is high |
| hi_byte_sel | input | 1 | 1 selects the upper result byte, 0 selects the lower |
| engine_result | input | 14 | Result word from the conversion engine |
| eoc_n | output | 1 | End of conversion, low while a result is ready |
| bus_dout | output | 8 | Output byte, zero when not driven |
| bus_oe | output | 1 | Output enable for an external tri-state driver |
| ref_on | output | 1 | Reference and buffer power enable |
| sampling | output | 1 | Track switch closed (acquisition) |

## Verification
Full conversion cycles are run twice: once with rd_cnv high at the second edge and once with it low, so the shutdown and standby paths can be told apart by ref_on after eoc_n falls. Results of zero, full scale and an irregular pattern are read in both byte halves; these separate a swapped byte order and a missing upper-bit pad. Edges that should be ignored are sent with the wrong rd_cnv level in idle and in the waiting state, and the engine word is changed after capture; these catch decoding that depends on the edge count alone. reset_req is issued with cs_n high and again with cs_n low, which shows whether the chip-select gate on reset works.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_STBY  = 3'd1,
        S_ACQ   = 3'd2,
        S_CONV  = 3'd3,
        S_WAIT  = 3'd4,
        S_READ  = 3'd5
    } seq_state_e;

    function automatic logic is_idle(seq_state_e s);
        return (s == S_OFF) || (s == S_STBY);
    endfunction

endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] sync_prev
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
        r_d.prev = r_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                r_q.chain[i] <= INIT;
            end
            r_q.prev <= INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_out  = r_q.chain[STAGES-1];
    assign sync_prev = r_q.prev;

    // the history flop always carries the previous synchronized sample
    p_prev_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sync_prev == $past(sync_out));
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        done = t_q.run && (t_q.cnt == LAST);
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
        end else if (t_q.run) begin
            if (t_q.cnt == LAST) begin
                t_d.run = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy = t_q.run;

    // completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);
    // counting starts fresh on every start request
    p_start_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/adc_byte_port.sv
module adc_byte_port #(
    parameter int RES_W  = 14,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_en,
    input  logic              hi_sel,
    input  logic [RES_W-1:0]  word,
    output logic [BYTE_W-1:0] dout,
    output logic              oe
);
    localparam int HI_W = RES_W - BYTE_W;
    localparam int PAD  = BYTE_W - HI_W;

    typedef struct packed {
        logic              en;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } port_regs_t;

    port_regs_t p_d, p_q;
    logic [BYTE_W-1:0] hi_byte;

    generate
        if (PAD > 0) begin : g_pad
            assign hi_byte = {{PAD{1'b0}}, word[RES_W-1:BYTE_W]};
        end else begin : g_nopad
            assign hi_byte = word[RES_W-1:BYTE_W];
        end
    endgenerate

    always_comb begin
        p_d    = p_q;
        p_d.en = drive_en;
        p_d.hi = hi_sel;
        if (drive_en) begin
            p_d.data = hi_sel ? hi_byte : word[BYTE_W-1:0];
        end else begin
            p_d.data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign dout = p_q.data;
    assign oe   = p_q.en;

    // an undriven port shows all zeros
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> dout == '0);
    // the upper byte has its unused top positions at zero
    p_upper_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe && p_q.hi |-> dout[BYTE_W-1 -: PAD] == '0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 14,
    parameter int BYTE_W      = 8,
    parameter int CONV_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_cnv,
    input  logic              reset_req,
    input  logic              hi_byte_sel,
    input  logic [RES_W-1:0]  engine_result,
    output logic              eoc_n,
    output logic [BYTE_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              ref_on,
    output logic              sampling
);
    localparam int NSYNC = 3;
    localparam int I_CS  = 0;
    localparam int I_RC  = 1;
    localparam int I_RST = 2;
    localparam logic [NSYNC-1:0] SYNC_INIT = NSYNC'(1) << I_CS;

    logic [NSYNC-1:0] s_now, s_prev;
    logic cs_fall, cs_rise, rc_s, cs_high, blk_rst;
    logic tmr_start, tmr_busy, tmr_done;

    adc_in_sync #(
        .W      (NSYNC),
        .STAGES (SYNC_STAGES),
        .INIT   (SYNC_INIT)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  ({reset_req, rd_cnv, cs_n}),
        .sync_out  (s_now),
        .sync_prev (s_prev)
    );

    assign cs_high = s_now[I_CS];
    assign cs_fall = s_prev[I_CS] && !s_now[I_CS];
    assign cs_rise = !s_prev[I_CS] && s_now[I_CS];
    assign rc_s    = s_now[I_RC];
    assign blk_rst = s_now[I_RST] && cs_high;

    typedef struct packed {
        seq_state_e       st;
        logic             pd;
        logic             ref_en;
        logic             eoc_n;
        logic             samp;
        logic [RES_W-1:0] result;
    } ctrl_regs_t;

    ctrl_regs_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        tmr_start = 1'b0;
        if (blk_rst) begin
            c_d.st     = S_OFF;
            c_d.ref_en = 1'b0;
            c_d.eoc_n  = 1'b1;
            c_d.samp   = 1'b0;
        end else begin
            unique case (c_q.st)
                S_OFF, S_STBY: begin
                    if (cs_fall && !rc_s) begin
                        c_d.st     = S_ACQ;
                        c_d.ref_en = 1'b1;
                        c_d.samp   = 1'b1;
                    end
                end
                S_ACQ: begin
                    if (cs_fall) begin
                        c_d.st    = S_CONV;
                        c_d.pd    = rc_s;
                        c_d.samp  = 1'b0;
                        tmr_start = 1'b1;
                    end
                end
                S_CONV: begin
                    if (tmr_done) begin
                        c_d.st     = S_WAIT;
                        c_d.eoc_n  = 1'b0;
                        c_d.result = engine_result;
                        c_d.ref_en = !c_q.pd;
                    end
                end
                S_WAIT: begin
                    if (cs_fall && rc_s) begin
                        c_d.st = S_READ;
                    end
                end
                S_READ: begin
                    if (cs_rise) begin
                        c_d.st    = c_q.pd ? S_OFF : S_STBY;
                        c_d.eoc_n = 1'b1;
                    end
                end
                default: begin
                    c_d.st = S_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st     <= S_OFF;
            c_q.pd     <= 1'b0;
            c_q.ref_en <= 1'b0;
            c_q.eoc_n  <= 1'b1;
            c_q.samp   <= 1'b0;
            c_q.result <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    adc_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    adc_byte_port #(
        .RES_W  (RES_W),
        .BYTE_W (BYTE_W)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_en (c_q.st == S_READ),
        .hi_sel   (hi_byte_sel),
        .word     (c_q.result),
        .dout     (bus_dout),
        .oe       (bus_oe)
    );

    assign eoc_n    = c_q.eoc_n;
    assign ref_on   = c_q.ref_en;
    assign sampling = c_q.samp;

    // the port never drives while tracking or converting
    p_quiet_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sampling || tmr_busy |-> !bus_oe);
    // a ready flag only ever follows a running conversion
    p_eoc_after_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> $past(c_q.st) == S_CONV);
    // shutdown choice turns the reference off once the result is ready
    p_shutdown_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) && c_q.pd |-> !ref_on);
    // an edge with rd_cnv high does nothing while idle
    p_ignore_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle(c_q.st) && cs_fall && rc_s && !blk_rst |=> $stable(c_q.st) && !sampling);
    // the port drives only while a ready result is flagged
    p_oe_needs_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !$past(eoc_n));
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    localparam int CONV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_cnv = 1'b0;
    logic        reset_req = 1'b0;
    logic        hi_byte_sel = 1'b0;
    logic [13:0] engine_result = '0;
    logic        eoc_n;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic        ref_on;
    logic        sampling;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.CONV_CYCLES(CONV)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cnv(rd_cnv),
        .reset_req(reset_req), .hi_byte_sel(hi_byte_sel),
        .engine_result(engine_result), .eoc_n(eoc_n), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .ref_on(ref_on), .sampling(sampling)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // one cs_n low pulse with a given rd_cnv level
    task automatic pulse(input logic rc);
        rd_cnv = rc;
        tick(1);
        cs_n = 1'b0;
        tick(6);
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic t_reset_state;
        chk("R1 eoc_n", eoc_n, 1);
        chk("R1 bus_oe", bus_oe, 0);
        chk("R1 ref_on", ref_on, 0);
        chk("R1 sampling", sampling, 0);
    endtask

    task automatic t_ignore_high;
        pulse(1'b1);
        chk("R3 sampling", sampling, 0);
        chk("R3 ref_on", ref_on, 0);
    endtask

    // full cycle: acquisition, conversion with a power choice, two-byte read
    task automatic t_cycle(input logic [13:0] val, input logic pd);
        pulse(1'b0);
        chk("R2 sampling", sampling, 1);
        chk("R2 ref_on", ref_on, 1);
        chk("R8 quiet in acquisition", bus_oe, 0);
        engine_result = val;
        rd_cnv = pd;
        tick(1);
        cs_n = 1'b0;
        tick(CONV + 1);
        chk("R4 sampling ended", sampling, 0);
        chk("R4 eoc_n still high", eoc_n, 1);
        chk("R8 quiet in conversion", bus_oe, 0);
        tick(4);
        chk("R4 eoc_n low", eoc_n, 0);
        chk("R5 ref_on after conversion", ref_on, pd ? 0 : 1);
        cs_n = 1'b1;
        engine_result = ~val;
        tick(6);
        chk("R8 quiet while waiting", bus_oe, 0);
        pulse(1'b0);
        chk("R12 bus_oe after low edge", bus_oe, 0);
        chk("R12 eoc_n still low", eoc_n, 0);
        rd_cnv = 1'b1;
        hi_byte_sel = 1'b0;
        tick(1);
        cs_n = 1'b0;
        tick(6);
        chk("R7 bus_oe", bus_oe, 1);
        chk("R9 R10 low byte", bus_dout, int'(val[7:0]));
        hi_byte_sel = 1'b1;
        tick(2);
        chk("R9 R10 high byte", bus_dout, int'({2'b00, val[13:8]}));
        cs_n = 1'b1;
        tick(6);
        chk("R7 bus_oe released", bus_oe, 0);
        chk("R6 eoc_n high", eoc_n, 1);
        chk("R6 ref_on idle", ref_on, pd ? 0 : 1);
        hi_byte_sel = 1'b0;
    endtask

    task automatic t_block_reset;
        pulse(1'b0);
        reset_req = 1'b1;
        tick(6);
        reset_req = 1'b0;
        tick(4);
        chk("R11 sampling", sampling, 0);
        chk("R11 ref_on", ref_on, 0);
        chk("R11 eoc_n", eoc_n, 1);
        pulse(1'b0);
        chk("R11 acquisition after reset", sampling, 1);
        // with cs_n held low the request is not taken
        rd_cnv = 1'b1;
        tick(1);
        cs_n = 1'b0;
        tick(4);
        reset_req = 1'b1;
        tick(6);
        reset_req = 1'b0;
        tick(4);
        chk("R11 ignored with cs_n low", ref_on, 1);
        cs_n = 1'b1;
        tick(CONV + 8);
        chk("R11 conversion kept", eoc_n, 0);
        reset_req = 1'b1;
        tick(6);
        reset_req = 1'b0;
        tick(4);
        chk("R11 reset from waiting", eoc_n, 1);
        chk("R11 ref_on from waiting", ref_on, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset_state();
        t_ignore_high();
        t_cycle(14'h2A5C, 1'b0);
        chk("R3 ignored in standby", ref_on, 1);
        pulse(1'b1);
        chk("R3 standby stays idle", sampling, 0);
        chk("R3 standby ref kept", ref_on, 1);
        t_cycle(14'h3FFF, 1'b1);
        t_cycle(14'h0000, 1'b0);
        t_block_reset();
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule